// File: doc/BRIEF.md
# UART Register Front End

This block is the register face of a simple serial port. A synchronous bus with a single-cycle select and write strobe can reach seven byte-wide locations. They hold the line format, a divisor split into two parts, the port enables, two status words and a data window. A write to the data window queues a byte for transmission. A read of the data window takes the oldest received byte. Each direction has its own first-in first-out store, `DEPTH` entries deep.

On the far side the block feeds a separate bit-level serial engine. Transmit bytes go out over a valid/ready handshake. Received bytes come in with their parity and framing error flags. Those flags stay attached to the byte inside the receive store, so the status word always describes the byte that the next data read will return. The engine also sends single-cycle pulses for receiver idle, break begin and break end. These pulses set sticky bits that software clears by writing one to them. A single level interrupt combines the FIFO fill levels and the sticky bits, each gated by its own enable.

Top module: `uart_regfront`

Offsets (word index on `bus_addr`): 0 format, 1 divisor high, 2 divisor low, 3 port control, 4 data, 5 event status, 6 line status, 7 unmapped.

## Requirements
- R1: A write to offset 4 queues `bus_wdata[7:0]` in the transmit store; a write while the store is full is discarded. `tx_valid` is high only while the transmit enable is set and the store is non-empty, and bytes leave on `tx_byte` in write order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R2: A read of offset 4 returns the oldest received byte and removes it at the clock edge that ends the read; on an empty store it returns 0 and removes nothing.
- R3: Line status at offset 6: bit 0 transmitter busy (store non-empty or `tx_line_busy`), bit 1 receive data present, bit 2 transmit store not full.
- R4: Line status bits 3 (parity error) and 4 (framing error) show the flags that arrived with the byte at the head of the receive store, and read 0 when the store is empty.
- R5: A byte that arrives while the receive store is full is dropped, and line status bit 5 (overrun) is set on the newest stored entry only.
- R6: Event status at offset 5: bit 0 is high while the transmit store holds `DEPTH`/2 entries or fewer, and bit 1 is high while the receive store holds more than `DEPTH`/2 entries.
- R7: Event status bits 2 (receiver idle), 3 (break begin) and 4 (break end) are set by their pulses and stay set. Writing one to a bit clears it, and writing 0xFF clears all three. A pulse in the same cycle as the clearing write wins.
- R8: Port control at offset 3: bit 0 receive enable, bit 1 transmit enable, bit 2 force break, bit 3 receive interrupt enable, bit 4 transmit interrupt enable. Writing 0 turns all of them off, and received bytes are ignored while receive enable is clear.
- R9: `cfg_divisor` is {offset 1 bits 3:0, offset 2 bits 7:0}; both read back as written.
- R10: Format at offset 0: bit 0 parity enable, bit 1 odd parity, bit 2 two stop bits, bit 3 eight data bits; the bits drive the matching `cfg_` outputs.
- R11: `irq` = (event bit 0 AND transmit interrupt enable) OR ((event bit 1, 2, 3 or 4) AND receive interrupt enable).
- R12: Reading offset 7 returns 0. Writes to offset 7 or offset 6 change nothing, and writes to offset 5 affect only bits 2 to 4.
- R13: After reset all control bits are 0, both stores are empty, line status reads 0x04, event status reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tx_byte | output | 8 | Byte offered to the serial engine |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the byte |
| tx_line_busy | input | 1 | Engine is still shifting bits out |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for `rx_byte` |
| rx_ferr | input | 1 | Framing error for `rx_byte` |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_ready | output | 1 | Receive path accepting (receive enable) |
| ev_brk_begin | input | 1 | Break-begin pulse |
| ev_brk_end | input | 1 | Break-end pulse |
| ev_rx_idle | input | 1 | Receiver-idle pulse |
| cfg_parity_en | output | 1 | Parity enabled |
| cfg_parity_odd | output | 1 | Odd parity selected |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_eight_bit | output | 1 | Eight data bits (else seven) |
| cfg_divisor | output | DIV_W | Baud divisor |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_break | output | 1 | Force break on the line |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the first clock edge after the strobe, so control, status and `irq` results are due one cycle after it. A data read shows the head byte in the same cycle and removes it at that edge. The bench drives each strobe on a falling edge and samples one nanosecond after the next falling edge, after exactly one rising edge has passed. Received bytes, engine pulses and handshakes are given a single-cycle window the same way, so every expected status word is computed for a known number of edges.

// File: rtl/uart_regfront_pkg.sv
// Package: register offsets and bit positions shared by the front end,
// its checker and its bench. Assumes an 8-bit register data path.
package uart_regfront_pkg;
    localparam int BUS_W     = 8;
    localparam int OFF_FMT   = 0;
    localparam int OFF_DIVHI = 1;
    localparam int OFF_DIVLO = 2;
    localparam int OFF_CTRL  = 3;
    localparam int OFF_DATA  = 4;
    localparam int OFF_EVT   = 5;
    localparam int OFF_LINE  = 6;
    // port control bit positions
    localparam int CB_RXEN = 0;
    localparam int CB_TXEN = 1;
    localparam int CB_BRK  = 2;
    localparam int CB_RXIE = 3;
    localparam int CB_TXIE = 4;
    localparam int CTRL_W  = 5;
    // event status: sticky bits occupy [EVT_LO +: EVT_N]
    localparam int EVT_LO = 2;
    localparam int EVT_N  = 3;
endpackage

// File: rtl/uart_rf_fifo.sv
// Module: uart_rf_fifo
// Synchronous first-in first-out store with a level count. A push while full
// is accepted only if a pop happens in the same cycle. mark_last sets the MSB
// of the newest stored entry. Assumes DEPTH is a power of two.
module uart_rf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    input  logic                       mark_last,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rptr];

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + PTR_W'(1);
            if (do_pop)  rptr <= rptr + PTR_W'(1);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // Entry storage, plus flag marking of the newest entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
        if (mark_last && !empty) mem[wptr - PTR_W'(1)][W-1] <= 1'b1;
    end
endmodule

// File: rtl/uart_rf_sticky.sv
// Module: uart_rf_sticky
// Bank of N sticky event bits. A set pulse raises a bit, a clear request
// lowers it, and a set in the same cycle wins over the clear.
module uart_rf_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    // One flop per event, generated per bit.
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_regfront.sv
// Module: uart_regfront
// Bus register front end of a UART. It decodes the register map, holds the
// two byte stores (received bytes carry their error flags), derives the
// fill-level service requests, keeps the write-one-to-clear event bits and
// gates the interrupt. Assumes a single-cycle bus strobe and DIV_W > 8.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DIV_W  = 12,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_line_busy,
    input  logic [7:0]        rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              ev_brk_begin,
    input  logic              ev_brk_end,
    input  logic              ev_rx_idle,
    output logic              cfg_parity_en,
    output logic              cfg_parity_odd,
    output logic              cfg_two_stop,
    output logic              cfg_eight_bit,
    output logic [DIV_W-1:0]  cfg_divisor,
    output logic              cfg_rx_en,
    output logic              cfg_tx_en,
    output logic              cfg_break,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int HALF  = DEPTH / 2;
    localparam int HI_W  = DIV_W - 8;
    localparam int RXE_W = 8 + 3;   // byte, parity, framing, overrun

    logic [3:0]        fmt_q;
    logic [HI_W-1:0]   divhi_q;
    logic [7:0]        divlo_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              rx_ie, tx_ie;

    logic wr_cycle, rd_cycle;
    assign wr_cycle = bus_sel && bus_wr;
    assign rd_cycle = bus_sel && !bus_wr;

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q   <= '0;
            divhi_q <= '0;
            divlo_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_cycle) begin
            case (int'(bus_addr))
                OFF_FMT:   fmt_q   <= bus_wdata[3:0];
                OFF_DIVHI: divhi_q <= bus_wdata[HI_W-1:0];
                OFF_DIVLO: divlo_q <= bus_wdata[7:0];
                OFF_CTRL:  ctrl_q  <= bus_wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    assign cfg_parity_en  = fmt_q[0];
    assign cfg_parity_odd = fmt_q[1];
    assign cfg_two_stop   = fmt_q[2];
    assign cfg_eight_bit  = fmt_q[3];
    assign cfg_divisor    = {divhi_q, divlo_q};
    assign cfg_rx_en      = ctrl_q[CB_RXEN];
    assign cfg_tx_en      = ctrl_q[CB_TXEN];
    assign cfg_break      = ctrl_q[CB_BRK];
    assign rx_ie          = ctrl_q[CB_RXIE];
    assign tx_ie          = ctrl_q[CB_TXIE];

    // Transmit store.
    logic [7:0]       tx_head;
    logic [CNT_W-1:0] tx_count;
    logic             tx_full, tx_empty, tx_push, tx_pop;

    assign tx_push = wr_cycle && (int'(bus_addr) == OFF_DATA);
    assign tx_pop  = tx_valid && tx_ready;

    uart_rf_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(bus_wdata[7:0]),
        .pop(tx_pop), .mark_last(1'b0),
        .dout(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    assign tx_valid = cfg_tx_en && !tx_empty;
    assign tx_byte  = tx_empty ? 8'h00 : tx_head;

    // Receive store: {overrun, framing, parity, byte} per entry.
    logic [RXE_W-1:0] rx_head_raw, rx_head;
    logic [CNT_W-1:0] rx_count;
    logic             rx_full, rx_empty, rx_push, rx_pop, rx_ovf;

    assign rx_ready = cfg_rx_en;
    assign rx_push  = rx_valid && cfg_rx_en;
    assign rx_pop   = rd_cycle && (int'(bus_addr) == OFF_DATA);
    assign rx_ovf   = rx_push && rx_full && !rx_pop;

    uart_rf_fifo #(.W(RXE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din({1'b0, rx_ferr, rx_perr, rx_byte}),
        .pop(rx_pop), .mark_last(rx_ovf),
        .dout(rx_head_raw), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    assign rx_head = rx_empty ? '0 : rx_head_raw;

    // Sticky events: [0] idle, [1] break begin, [2] break end.
    logic [EVT_N-1:0] evt_q, evt_clr;
    assign evt_clr = (wr_cycle && int'(bus_addr) == OFF_EVT) ?
                     bus_wdata[EVT_LO +: EVT_N] : '0;

    uart_rf_sticky #(.N(EVT_N)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .set({ev_brk_end, ev_brk_begin, ev_rx_idle}),
        .clr(evt_clr), .q(evt_q)
    );

    // Service requests and interrupt gating.
    logic tx_svc, rx_svc;
    assign tx_svc = (tx_count <= CNT_W'(HALF));
    assign rx_svc = (rx_count >  CNT_W'(HALF));
    assign irq    = (tx_svc && tx_ie) || ((rx_svc || (|evt_q)) && rx_ie);

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFF_FMT:   bus_rdata = {4'b0, fmt_q};
            OFF_DIVHI: bus_rdata = BUS_W'(divhi_q);
            OFF_DIVLO: bus_rdata = divlo_q;
            OFF_CTRL:  bus_rdata = BUS_W'(ctrl_q);
            OFF_DATA:  bus_rdata = rx_head[7:0];
            OFF_EVT:   bus_rdata = {3'b0, evt_q, rx_svc, tx_svc};
            OFF_LINE:  bus_rdata = {2'b0, rx_head[10], rx_head[9], rx_head[8],
                                    !tx_full, !rx_empty,
                                    (!tx_empty || tx_line_busy)};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_regfront_chk.sv
// Module: uart_regfront_chk
// Property checker for uart_regfront, attached by the bind below. Observes
// ports plus the receive level, the sticky bits and the interrupt enables.
module uart_regfront_chk
    import uart_regfront_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [BUS_W-1:0]         bus_wdata,
    input logic [7:0]               tx_byte,
    input logic                     tx_valid,
    input logic                     tx_ready,
    input logic                     rx_valid,
    input logic                     cfg_rx_en,
    input logic                     cfg_tx_en,
    input logic                     cfg_break,
    input logic                     ev_brk_begin,
    input logic                     ev_brk_end,
    input logic                     ev_rx_idle,
    input logic [$clog2(DEPTH):0]   rx_count,
    input logic [EVT_N-1:0]         evt_q,
    input logic                     rx_ie,
    input logic                     tx_ie,
    input logic                     irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic ctrl_wr, evt_wr;
    assign ctrl_wr = bus_sel && bus_wr && int'(bus_addr) == OFF_CTRL;
    assign evt_wr  = bus_sel && bus_wr && int'(bus_addr) == OFF_EVT;

    // R1: an offered byte that is not taken stays on offer unchanged.
    p_hold_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !ctrl_wr) |=> (tx_valid && $stable(tx_byte)));

    // R5: the receive level never passes the depth, even under overrun.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH));

    // R5: a byte arriving on a full, unread store leaves it full.
    p_full_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_rx_en && rx_count == CNT_W'(DEPTH) && !bus_sel)
        |=> (rx_count == CNT_W'(DEPTH)));

    // R7: an all-ones write with no pulse pending clears every event bit.
    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && bus_wdata == 8'hFF && !ev_brk_begin && !ev_brk_end && !ev_rx_idle)
        |=> (evt_q == '0));

    // R7: an idle pulse is always recorded.
    p_idle_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_idle |=> evt_q[0]);

    // R8: writing zero to port control turns the port and break off.
    p_port_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == 8'h00) |=> (!cfg_rx_en && !cfg_tx_en && !cfg_break));

    // R11: with both enables clear the interrupt stays low.
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en),
    .cfg_break(cfg_break), .ev_brk_begin(ev_brk_begin), .ev_brk_end(ev_brk_end),
    .ev_rx_idle(ev_rx_idle), .rx_count(rx_count), .evt_q(evt_q),
    .rx_ie(rx_ie), .tx_ie(tx_ie), .irq(irq)
);

// File: tb/uart_regfront_tb_top.sv
// Bench for uart_regfront: a register vector table walked in one loop, then
// directed tests of the stores, status words, events and interrupt.
module uart_regfront_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] tx_byte;
    logic       tx_valid, tx_ready = 1'b0, tx_line_busy = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_valid = 1'b0, rx_ready;
    logic       ev_brk_begin = 1'b0, ev_brk_end = 1'b0, ev_rx_idle = 1'b0;
    logic       cfg_parity_en, cfg_parity_odd, cfg_two_stop, cfg_eight_bit;
    logic [11:0] cfg_divisor;
    logic       cfg_rx_en, cfg_tx_en, cfg_break, irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_regfront dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_line_busy(tx_line_busy),
        .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_valid(rx_valid), .rx_ready(rx_ready),
        .ev_brk_begin(ev_brk_begin), .ev_brk_end(ev_brk_end), .ev_rx_idle(ev_rx_idle),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_eight_bit(cfg_eight_bit),
        .cfg_divisor(cfg_divisor), .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en),
        .cfg_break(cfg_break), .irq(irq)
    );

    // {offset, write value, expected read-back}
    localparam logic [23:0] VECS [9] = '{
        {8'd0, 8'hFF, 8'h0F},   // R10 format keeps 4 bits
        {8'd1, 8'hFF, 8'h0F},   // R9 divisor high keeps 4 bits
        {8'd2, 8'h5A, 8'h5A},   // R9 divisor low
        {8'd3, 8'hFF, 8'h1F},   // R8 control keeps 5 bits
        {8'd3, 8'h00, 8'h00},   // R8 zero turns all off
        {8'd7, 8'hFF, 8'h00},   // R12 unmapped reads 0
        {8'd6, 8'hFF, 8'h04},   // R12 line status not writable
        {8'd5, 8'hFF, 8'h01},   // R12 event level bits not writable
        {8'd0, 8'h09, 8'h09}    // R10 eight bits, parity on, even
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic pe, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
        #1;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R13 reset state
        chk("R13 irq", irq, 0);
        chk("R13 tx_valid", tx_valid, 0);
        bus_read(3'd3, r); chk("R13 control", r, 8'h00);
        bus_read(3'd6, r); chk("R13 line status", r, 8'h04);
        bus_read(3'd5, r); chk("R13 event status", r, 8'h01);

        // Vector table: R8 R9 R10 R12
        for (int i = 0; i < 9; i++) begin
            bus_write(VECS[i][18:16], VECS[i][15:8]);
            bus_read(VECS[i][18:16], r);
            chk("R8/R9/R10/R12 table", r, VECS[i][7:0]);
        end
        chk("R9 divisor", cfg_divisor, 12'hF5A);
        chk("R10 format pins", {cfg_eight_bit, cfg_two_stop, cfg_parity_odd, cfg_parity_en}, 4'b1001);

        // R8 control pins
        bus_write(3'd3, 8'h07);
        chk("R8 enables on", {cfg_break, cfg_tx_en, cfg_rx_en, rx_ready}, 4'b1111);
        bus_write(3'd3, 8'h00);
        chk("R8 enables off", {cfg_break, cfg_tx_en, cfg_rx_en, rx_ready}, 4'b0000);

        // R1 transmit: fill with transmit disabled, ninth write dropped
        for (int i = 0; i < 9; i++) bus_write(3'd4, 8'h10 + 8'(i));
        chk("R1 held while disabled", tx_valid, 0);
        bus_read(3'd6, r); chk("R3 full store status", r, 8'h01);
        bus_read(3'd5, r); chk("R6 tx level above half", r, 8'h00);
        bus_write(3'd3, 8'h02);
        for (int i = 0; i < 8; i++) begin
            chk("R1 tx_valid", tx_valid, 1);
            chk("R1 tx order", tx_byte, 8'h10 + 8'(i));
            tx_ready = 1'b1;
            @(negedge clk); #1;
        end
        tx_ready = 1'b0;
        chk("R1 ninth byte dropped", tx_valid, 0);
        tx_line_busy = 1'b1;
        bus_read(3'd6, r); chk("R3 busy from line", r, 8'h05);
        tx_line_busy = 1'b0;
        bus_read(3'd6, r); chk("R3 idle", r, 8'h04);

        // R2 R4 receive with per-byte flags
        bus_write(3'd3, 8'h01);
        rx_send(8'hA1, 1'b1, 1'b0);
        rx_send(8'hB2, 1'b0, 1'b1);
        rx_send(8'hC3, 1'b0, 1'b0);
        bus_read(3'd6, r); chk("R4 parity at head", r, 8'h0E);
        bus_read(3'd4, r); chk("R2 first byte", r, 8'hA1);
        bus_read(3'd6, r); chk("R4 framing at head", r, 8'h16);
        bus_read(3'd4, r); chk("R2 second byte", r, 8'hB2);
        bus_read(3'd6, r); chk("R4 clean head", r, 8'h06);
        bus_read(3'd4, r); chk("R2 third byte", r, 8'hC3);
        bus_read(3'd6, r); chk("R3 receive empty", r, 8'h04);
        bus_read(3'd4, r); chk("R2 empty read", r, 8'h00);

        // R8 receive disabled ignores bytes
        bus_write(3'd3, 8'h00);
        rx_send(8'h55, 1'b0, 1'b0);
        bus_read(3'd6, r); chk("R8 rx ignored", r, 8'h04);

        // R6 R11 R5 levels, interrupt, overrun
        bus_write(3'd3, 8'h09);
        for (int i = 0; i < 4; i++) rx_send(8'h20 + 8'(i), 1'b0, 1'b0);
        bus_read(3'd5, r); chk("R6 rx at half", r, 8'h01);
        chk("R11 no rx irq at half", irq, 0);
        rx_send(8'h24, 1'b0, 1'b0);
        bus_read(3'd5, r); chk("R6 rx above half", r, 8'h03);
        chk("R11 rx irq", irq, 1);
        for (int i = 5; i < 8; i++) rx_send(8'h20 + 8'(i), 1'b0, 1'b0);
        rx_send(8'hEE, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            bus_read(3'd6, r);
            chk("R5 overrun only on newest", r, (i == 7) ? 8'h26 : 8'h06);
            bus_read(3'd4, r);
            chk("R5 stored bytes", r, 8'h20 + 8'(i));
        end
        bus_read(3'd6, r); chk("R5 extra byte dropped", r, 8'h04);

        // R7 R11 sticky events
        bus_write(3'd3, 8'h08);
        chk("R11 quiet", irq, 0);
        @(negedge clk); ev_rx_idle = 1'b1; @(negedge clk); ev_rx_idle = 1'b0; #1;
        bus_read(3'd5, r); chk("R7 idle sticky", r, 8'h05);
        chk("R11 event irq", irq, 1);
        bus_write(3'd3, 8'h00);
        chk("R11 gated off", irq, 0);
        bus_write(3'd3, 8'h08);
        @(negedge clk); ev_brk_begin = 1'b1; @(negedge clk); ev_brk_begin = 1'b0;
        ev_brk_end = 1'b1; @(negedge clk); ev_brk_end = 1'b0; #1;
        bus_read(3'd5, r); chk("R7 breaks sticky", r, 8'h1D);
        bus_write(3'd5, 8'h04);
        bus_read(3'd5, r); chk("R7 clear one", r, 8'h19);
        bus_write(3'd5, 8'hFF);
        bus_read(3'd5, r); chk("R7 clear all", r, 8'h01);
        chk("R11 cleared", irq, 0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 8'hFF;
        ev_brk_begin = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev_brk_begin = 1'b0; #1;
        bus_read(3'd5, r); chk("R7 set wins", r, 8'h09);
        bus_write(3'd5, 8'hFF);
        bus_write(3'd3, 8'h10);
        chk("R11 tx irq", irq, 1);
        bus_write(3'd3, 8'h00);
        chk("R11 tx irq off", irq, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule